// File: doc/BRIEF.md
# SIMT Reconvergence Stack Controller

This block tracks divergent control flow for a single fixed-width warp. It keeps a small stack of entries, each made of a reconvergence PC, a next PC and a per-thread active mask. The issue stage always takes the PC and the active mask of the warp from the top entry. When a branch resolves, the branch unit supplies the fall-through PC, the taken target, the reconvergence PC and the per-thread taken mask in a single cycle. If only some active threads take the branch, the top entry is parked at the reconvergence point and one entry is pushed for each side. Each pushed entry runs on its own until its next PC reaches its reconvergence PC. At that point it is retired.

Straight-line progress is reported through an advance request that carries the new next PC. After every update the top entry is compared again with its reconvergence PC. While a retirement is pending, the issue-valid output is low. The bottom entry has no reconvergence point, so it stays in place for the whole life of the warp. Two sticky error flags report a split that would not fit in the stack and a request made against a top entry that is being retired.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds one entry: depth is 1, the issued PC is START_PC, the issued mask is all ones, issue_vld is 1, and both error flags are 0.
- R2: issue_pc and issue_mask always equal the next PC and the mask of the top entry.
- R3: An advance request (adv_vld) accepted while issue_vld is 1 replaces the next PC of the top entry with adv_pc. The new value is visible on issue_pc after the next clock edge.
- R4: A branch is divergent when the taken threads (br_taken AND the current mask) and the not-taken threads (current mask AND NOT br_taken) are both non-empty. A divergent branch rewrites the top entry's next PC to br_rpc. It then pushes the not-taken entry (br_rpc, br_fall_pc, not-taken mask), and above it the taken entry (br_rpc, br_tgt_pc, taken mask). Depth grows by 2.
- R5: A non-divergent branch pushes nothing. If every active thread is taken, the top entry's next PC becomes br_tgt_pc. If no active thread is taken, it becomes br_fall_pc. Bits of br_taken outside the current mask have no effect.
- R6: When a non-bottom top entry has a next PC equal to its reconvergence PC, issue_vld is 0 for that cycle and the entry is removed at the next clock edge. This removes one entry per cycle, so stacked entries that share a reconvergence point unwind over consecutive cycles.
- R7: The bottom entry carries no reconvergence PC and is never removed. Depth stays between 1 and DEPTH.
- R8: A divergent branch that would make depth exceed DEPTH sets ovf_err and leaves the stack unchanged. ovf_err stays set until reset.
- R9: An advance or branch request made while issue_vld is 0 is discarded. The pending removal still happens, and ufl_err is set and stays set until reset.
- R10: When adv_vld and br_vld are asserted together, the branch is applied and the advance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_vld | input | 1 | Sequential advance request |
| adv_pc | input | PC_W | New next PC for the top entry |
| br_vld | input | 1 | Resolved branch request |
| br_fall_pc | input | PC_W | Fall-through PC |
| br_tgt_pc | input | PC_W | Taken target PC |
| br_rpc | input | PC_W | Reconvergence PC of the branch |
| br_taken | input | W | Per-thread taken mask |
| issue_vld | output | 1 | Top entry is stable and may issue |
| issue_pc | output | PC_W | Next PC of the top entry |
| issue_mask | output | W | Active mask of the top entry |
| depth | output | $clog2(DEPTH+1) | Number of live entries |
| ovf_err | output | 1 | Sticky overflow flag |
| ufl_err | output | 1 | Sticky flag for a request made during a retirement |

## Verification
The main path is driven through the full split, run and rejoin sequence of a 4-thread warp. This shows that the taken side is issued before the not-taken side, and that the bottom entry comes back with the full mask. Uniform branches with an all-taken mask and with an empty mask tell target selection apart from fall-through selection without any push. A taken mask that carries bits outside the active threads shows that those bits are masked off. A nested split that reuses the outer reconvergence PC shows that retirements unwind one per cycle. Directed sequences fill the stack to overflow, send a request while a retirement is pending, and assert both requests at once. These separate the discarded stimulus from the stimulus that is applied.

// File: rtl/simt_stk_pkg.sv
package simt_stk_pkg;
  // Update applied to the stack storage in one cycle
  typedef enum logic [1:0] {
    ACT_HOLD     = 2'd0,
    ACT_SET_NEXT = 2'd1,
    ACT_SPLIT    = 2'd2,
    ACT_POP      = 2'd3
  } stk_act_e;
endpackage

// File: rtl/simt_br_classify.sv
module simt_br_classify #(
  parameter int W = 4
) (
  input  logic [W-1:0] act_mask,
  input  logic [W-1:0] raw_taken,
  output logic [W-1:0] tk_mask,
  output logic [W-1:0] nt_mask,
  output logic         divergent,
  output logic         all_taken
);
  // Threads that are not active never take part in the split
  always_comb begin
    tk_mask   = raw_taken & act_mask;
    nt_mask   = act_mask & ~raw_taken;
    all_taken = (nt_mask == '0);
    divergent = (|tk_mask) && (|nt_mask);
  end
endmodule

// File: rtl/simt_stk_store.sv
module simt_stk_store
  import simt_stk_pkg::*;
#(
  parameter int          W        = 4,
  parameter int          PC_W     = 16,
  parameter int          DEPTH    = 8,
  parameter int          SP_W     = $clog2(DEPTH),
  parameter logic [15:0] START_PC = 16'h0000
) (
  input  logic            clk,
  input  logic            rst,
  input  stk_act_e        act,
  input  logic [PC_W-1:0] wr_next,
  input  logic [PC_W-1:0] sp_rpc,
  input  logic [PC_W-1:0] sp_nt_pc,
  input  logic [PC_W-1:0] sp_tk_pc,
  input  logic [W-1:0]    sp_nt_mask,
  input  logic [W-1:0]    sp_tk_mask,
  output logic [SP_W-1:0] sp,
  output logic            top_rvld,
  output logic [PC_W-1:0] top_rpc,
  output logic [PC_W-1:0] top_next,
  output logic [W-1:0]    top_mask
);
  logic [PC_W-1:0] nxt_q  [DEPTH];
  logic [PC_W-1:0] rpc_q  [DEPTH];
  logic [W-1:0]    msk_q  [DEPTH];
  logic            rvld_q [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] sp_up1;
  logic [SP_W-1:0] sp_up2;

  assign sp_up1 = sp_q + SP_W'(1);
  assign sp_up2 = sp_q + SP_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
    end else begin
      case (act)
        ACT_SPLIT: sp_q <= sp_up2;
        ACT_POP:   sp_q <= sp_q - SP_W'(1);
        default:   sp_q <= sp_q;
      endcase
    end
  end

  // Entry storage; only the bottom slot takes a reset value
  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_q[0]  <= PC_W'(START_PC);
      rpc_q[0]  <= '0;
      msk_q[0]  <= '1;
      rvld_q[0] <= 1'b0;
    end else begin
      case (act)
        ACT_SET_NEXT: nxt_q[sp_q] <= wr_next;
        ACT_SPLIT: begin
          nxt_q[sp_q]    <= sp_rpc;
          rpc_q[sp_up1]  <= sp_rpc;
          nxt_q[sp_up1]  <= sp_nt_pc;
          msk_q[sp_up1]  <= sp_nt_mask;
          rvld_q[sp_up1] <= 1'b1;
          rpc_q[sp_up2]  <= sp_rpc;
          nxt_q[sp_up2]  <= sp_tk_pc;
          msk_q[sp_up2]  <= sp_tk_mask;
          rvld_q[sp_up2] <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign sp       = sp_q;
  assign top_rvld = rvld_q[sp_q];
  assign top_rpc  = rpc_q[sp_q];
  assign top_next = nxt_q[sp_q];
  assign top_mask = msk_q[sp_q];
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_stk_pkg::*;
#(
  parameter int          W        = 4,
  parameter int          PC_W     = 16,
  parameter int          DEPTH    = 8,
  parameter logic [15:0] START_PC = 16'h0000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       adv_vld,
  input  logic [PC_W-1:0]            adv_pc,
  input  logic                       br_vld,
  input  logic [PC_W-1:0]            br_fall_pc,
  input  logic [PC_W-1:0]            br_tgt_pc,
  input  logic [PC_W-1:0]            br_rpc,
  input  logic [W-1:0]               br_taken,
  output logic                       issue_vld,
  output logic [PC_W-1:0]            issue_pc,
  output logic [W-1:0]               issue_mask,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic                       ovf_err,
  output logic                       ufl_err
);
  localparam int SP_W  = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  stk_act_e        act;
  logic [PC_W-1:0] wr_next;
  logic [SP_W-1:0] sp;
  logic            top_rvld;
  logic [PC_W-1:0] top_rpc;
  logic [PC_W-1:0] top_next;
  logic [W-1:0]    top_mask;
  logic [W-1:0]    tk_mask;
  logic [W-1:0]    nt_mask;
  logic            divergent;
  logic            all_taken;
  logic            pop_pend;
  logic            no_room;
  logic            set_ovf;
  logic            set_ufl;
  logic            ovf_q;
  logic            ufl_q;

  simt_br_classify #(.W(W)) u_cls (
    .act_mask (top_mask),
    .raw_taken(br_taken),
    .tk_mask  (tk_mask),
    .nt_mask  (nt_mask),
    .divergent(divergent),
    .all_taken(all_taken)
  );

  simt_stk_store #(
    .W(W), .PC_W(PC_W), .DEPTH(DEPTH), .SP_W(SP_W), .START_PC(START_PC)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .wr_next   (wr_next),
    .sp_rpc    (br_rpc),
    .sp_nt_pc  (br_fall_pc),
    .sp_tk_pc  (br_tgt_pc),
    .sp_nt_mask(nt_mask),
    .sp_tk_mask(tk_mask),
    .sp        (sp),
    .top_rvld  (top_rvld),
    .top_rpc   (top_rpc),
    .top_next  (top_next),
    .top_mask  (top_mask)
  );

  // Retire the top entry once it has reached its join point
  assign pop_pend = top_rvld && (top_next == top_rpc);
  // Two more entries must fit: (sp + 1) + 2 <= DEPTH
  assign no_room  = (int'(sp) + 3) > DEPTH;

  always_comb begin
    act     = ACT_HOLD;
    wr_next = adv_pc;
    set_ovf = 1'b0;
    set_ufl = 1'b0;
    if (pop_pend) begin
      act     = ACT_POP;
      set_ufl = adv_vld || br_vld;
    end else if (br_vld) begin
      if (divergent) begin
        if (no_room) set_ovf = 1'b1;
        else         act     = ACT_SPLIT;
      end else begin
        act     = ACT_SET_NEXT;
        wr_next = all_taken ? br_tgt_pc : br_fall_pc;
      end
    end else if (adv_vld) begin
      act = ACT_SET_NEXT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      ufl_q <= 1'b0;
    end else begin
      ovf_q <= ovf_q | set_ovf;
      ufl_q <= ufl_q | set_ufl;
    end
  end

  assign issue_vld  = !pop_pend;
  assign issue_pc   = top_next;
  assign issue_mask = top_mask;
  assign depth      = CNT_W'(sp) + CNT_W'(1);
  assign ovf_err    = ovf_q;
  assign ufl_err    = ufl_q;
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
  parameter int W     = 4,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       adv_vld,
  input logic [PC_W-1:0]            adv_pc,
  input logic                       br_vld,
  input logic                       issue_vld,
  input logic [PC_W-1:0]            issue_pc,
  input logic [W-1:0]               issue_mask,
  input logic [$clog2(DEPTH+1)-1:0] depth,
  input logic                       ovf_err,
  input logic                       ufl_err
);
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (rst)
    issue_mask != '0);  // R2
  AST_ADV_WRITES_TOP: assert property (@(posedge clk) disable iff (rst)
    issue_vld && adv_vld && !br_vld |=> issue_pc == $past(adv_pc));  // R3
  AST_POP_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !issue_vld |=> depth == $past(depth) - 1'b1);  // R6
  AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (rst)
    depth >= 1 && depth <= DEPTH);  // R7
  AST_BOTTOM_KEPT: assert property (@(posedge clk) disable iff (rst)
    depth == 1 |-> issue_vld);  // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);  // R8
  AST_OVF_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_err) |-> $stable(depth) && $stable(issue_pc) && $stable(issue_mask));  // R8
  AST_UFL_STICKY: assert property (@(posedge clk) disable iff (rst)
    ufl_err |=> ufl_err);  // R9
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
  .W(W), .PC_W(PC_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .adv_vld(adv_vld), .adv_pc(adv_pc), .br_vld(br_vld),
  .issue_vld(issue_vld), .issue_pc(issue_pc), .issue_mask(issue_mask),
  .depth(depth), .ovf_err(ovf_err), .ufl_err(ufl_err)
);

// File: tb/test_simt_reconv_stack.sv
`timescale 1ns/1ps
module test_simt_reconv_stack;
  localparam int          W     = 4;
  localparam int          PC_W  = 16;
  localparam int          DEPTH = 6;
  localparam logic [15:0] SPC   = 16'h000A;
  localparam int          CW    = $clog2(DEPTH+1);

  typedef struct packed {
    logic            adv;
    logic            br;
    logic [PC_W-1:0] a;   // adv_pc and br_fall_pc
    logic [PC_W-1:0] t;   // br_tgt_pc
    logic [PC_W-1:0] r;   // br_rpc
    logic [W-1:0]    m;   // br_taken
    logic            ev;
    logic [PC_W-1:0] ep;
    logic [W-1:0]    em;
    logic [CW-1:0]   ed;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,16'h000B,16'h0000,16'h0000,4'h0, 1'b1,16'h000B,4'hF,3'd1}, // advance
    '{1'b0,1'b1,16'h000D,16'h000C,16'h000E,4'h9, 1'b1,16'h000C,4'h9,3'd3}, // split, taken on top
    '{1'b1,1'b0,16'h000E,16'h0000,16'h0000,4'h0, 1'b0,16'h000E,4'h9,3'd3}, // reach join
    '{1'b0,1'b0,16'h0000,16'h0000,16'h0000,4'h0, 1'b1,16'h000D,4'h6,3'd2}, // not-taken side
    '{1'b1,1'b0,16'h000E,16'h0000,16'h0000,4'h0, 1'b0,16'h000E,4'h6,3'd2},
    '{1'b0,1'b0,16'h0000,16'h0000,16'h0000,4'h0, 1'b1,16'h000E,4'hF,3'd1}, // rejoined
    '{1'b1,1'b0,16'h0010,16'h0000,16'h0000,4'h0, 1'b1,16'h0010,4'hF,3'd1},
    '{1'b0,1'b1,16'h0011,16'h0020,16'h0030,4'hF, 1'b1,16'h0020,4'hF,3'd1}, // all taken
    '{1'b0,1'b1,16'h0021,16'h0025,16'h0030,4'h0, 1'b1,16'h0021,4'hF,3'd1}, // none taken
    '{1'b0,1'b1,16'h0022,16'h0023,16'h0040,4'h3, 1'b1,16'h0023,4'h3,3'd3}, // outer split
    '{1'b0,1'b1,16'h0024,16'h0025,16'h0040,4'hD, 1'b1,16'h0025,4'h1,3'd5}, // inner, stray bits
    '{1'b1,1'b0,16'h0040,16'h0000,16'h0000,4'h0, 1'b0,16'h0040,4'h1,3'd5},
    '{1'b0,1'b0,16'h0000,16'h0000,16'h0000,4'h0, 1'b1,16'h0024,4'h2,3'd4},
    '{1'b1,1'b0,16'h0040,16'h0000,16'h0000,4'h0, 1'b0,16'h0040,4'h2,3'd4},
    '{1'b0,1'b0,16'h0000,16'h0000,16'h0000,4'h0, 1'b0,16'h0040,4'h3,3'd3}, // chained retire
    '{1'b0,1'b0,16'h0000,16'h0000,16'h0000,4'h0, 1'b1,16'h0022,4'hC,3'd2},
    '{1'b1,1'b0,16'h0040,16'h0000,16'h0000,4'h0, 1'b0,16'h0040,4'hC,3'd2},
    '{1'b0,1'b0,16'h0000,16'h0000,16'h0000,4'h0, 1'b1,16'h0040,4'hF,3'd1}  // bottom again
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            adv_vld = 1'b0;
  logic [PC_W-1:0] adv_pc = '0;
  logic            br_vld = 1'b0;
  logic [PC_W-1:0] br_fall_pc = '0;
  logic [PC_W-1:0] br_tgt_pc = '0;
  logic [PC_W-1:0] br_rpc = '0;
  logic [W-1:0]    br_taken = '0;
  logic            issue_vld;
  logic [PC_W-1:0] issue_pc;
  logic [W-1:0]    issue_mask;
  logic [CW-1:0]   depth;
  logic            ovf_err;
  logic            ufl_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  simt_reconv_stack #(.W(W), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(SPC)) i_simt_reconv_stack (
    .clk(clk), .rst(rst), .adv_vld(adv_vld), .adv_pc(adv_pc), .br_vld(br_vld),
    .br_fall_pc(br_fall_pc), .br_tgt_pc(br_tgt_pc), .br_rpc(br_rpc), .br_taken(br_taken),
    .issue_vld(issue_vld), .issue_pc(issue_pc), .issue_mask(issue_mask), .depth(depth),
    .ovf_err(ovf_err), .ufl_err(ufl_err)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Drive one cycle of requests at a falling edge; return at the next falling edge
  task automatic step(input logic av, input logic bv, input logic [PC_W-1:0] a,
                      input logic [PC_W-1:0] t, input logic [PC_W-1:0] r, input logic [W-1:0] m);
    adv_vld = av; adv_pc = a; br_vld = bv; br_fall_pc = a; br_tgt_pc = t; br_rpc = r; br_taken = m;
    @(negedge clk);
    adv_vld = 1'b0; br_vld = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 depth", 32'(depth), 32'd1);
    chk("R1 pc", 32'(issue_pc), 32'(SPC));
    chk("R1 mask", 32'(issue_mask), 32'hF);
    chk("R1 vld", 32'(issue_vld), 32'd1);
    chk("R1 flags", {30'd0, ovf_err, ufl_err}, 32'd0);

    // Vector walk covering R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].adv, VECS[i].br, VECS[i].a, VECS[i].t, VECS[i].r, VECS[i].m);
      chk($sformatf("R2/R3/R4/R5/R6/R7 row %0d vld", i), 32'(issue_vld), 32'(VECS[i].ev));
      chk($sformatf("R2/R3/R4/R5/R6/R7 row %0d pc", i), 32'(issue_pc), 32'(VECS[i].ep));
      chk($sformatf("R2/R3/R4/R5/R6/R7 row %0d mask", i), 32'(issue_mask), 32'(VECS[i].em));
      chk($sformatf("R2/R3/R4/R5/R6/R7 row %0d depth", i), 32'(depth), 32'(VECS[i].ed));
    end
    chk("R7 bottom flags clear", {30'd0, ovf_err, ufl_err}, 32'd0);

    // R8 overflow: fill to depth 5 of 6, then split again
    do_reset();
    step(1'b0, 1'b1, 16'h0050, 16'h0051, 16'h005F, 4'h7);
    step(1'b0, 1'b1, 16'h0052, 16'h0053, 16'h005E, 4'h3);
    chk("R4 depth before overflow", 32'(depth), 32'd5);
    step(1'b0, 1'b1, 16'h0054, 16'h0055, 16'h005D, 4'h1);
    chk("R8 ovf set", 32'(ovf_err), 32'd1);
    chk("R8 depth unchanged", 32'(depth), 32'd5);
    chk("R8 pc unchanged", 32'(issue_pc), 32'h53);
    chk("R8 mask unchanged", 32'(issue_mask), 32'h3);

    // R9 request during a pending retirement
    step(1'b1, 1'b0, 16'h005E, 16'h0000, 16'h0000, 4'h0);
    chk("R6 pending vld", 32'(issue_vld), 32'd0);
    step(1'b1, 1'b1, 16'h0077, 16'h0078, 16'h0079, 4'h3);
    chk("R9 ufl set", 32'(ufl_err), 32'd1);
    chk("R9 pc after retire", 32'(issue_pc), 32'h52);
    chk("R9 mask after retire", 32'(issue_mask), 32'h4);
    chk("R9 depth after retire", 32'(depth), 32'd4);

    // R10 branch wins over advance
    step(1'b1, 1'b1, 16'h0061, 16'h0060, 16'h0070, 4'h4);
    chk("R10 pc", 32'(issue_pc), 32'h60);
    chk("R10 depth", 32'(depth), 32'd4);
    chk("R8 ovf sticky", 32'(ovf_err), 32'd1);
    chk("R9 ufl sticky", 32'(ufl_err), 32'd1);

    do_reset();
    chk("R1 flags cleared by reset", {30'd0, ovf_err, ufl_err}, 32'd0);
    chk("R1 depth after reset", 32'(depth), 32'd1);

    finish_run();
  end
endmodule